// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block receives asynchronous serial bytes from a single line that idles high. A strobe at eight times the bit rate paces all sampling, and the line is examined only on cycles where that strobe is high. The line first passes through a two-flop synchronizer. A falling line starts a check for a valid start bit. Once the start bit is accepted, the receiver takes one sample every eight strobes, which places each sample near the middle of its bit. Data arrives least significant bit first and is collected in a shift register. At the stop-bit sample the byte moves into a holding register and a ready flag rises.

The host sees the held byte, a ready flag, an overrun flag and a framing-error flag. A one-cycle read strobe empties the holding register. If a new byte completes while the previous one is still unread, the new byte is dropped, the old byte stays, and the overrun flag is set until the next read. A low stop-bit sample marks a framing error. That byte is still delivered, and the receiver then waits for the line to go high before it looks for a new start.

The controller has five states. IDLE goes to START_CHK on a low sample. START_CHK goes back to IDLE on a high sample, and goes to DATA once the required run of low samples is complete. DATA goes to STOP after the last data bit is sampled. STOP goes to IDLE when the stop sample is high and to WAIT_HIGH when it is low. WAIT_HIGH goes to IDLE on the first high sample.

Top module: `os_uart_rx`

## Requirements
- R1: After reset, `byte_ready`, `overrun` and `frame_err` are 0 and `rx_byte` is 0x00.
- R2: The line reaches the controller only through a two-flop synchronizer, and the controller changes state only on cycles where `os_tick` is 1. A line held low while `os_tick` stays 0 produces no byte.
- R3: A start bit is accepted only after CONFIRM (default 4) consecutive low samples, counting the first one. A high sample before that returns the receiver to IDLE. A low pulse that covers 2 or 3 ticks produces no byte.
- R4: After the start bit is accepted, data bit 0 is sampled on the OSR-th (default 8th) tick, and each later bit OSR ticks after the one before it. The first data bit on the line lands in `rx_byte` bit 0 (least significant bit first).
- R5: On the tick that samples the stop bit, the assembled byte is copied to `rx_byte` and `byte_ready` becomes 1 on the following clock.
- R6: A `host_rd` pulse clears `byte_ready` and `overrun`. A read while `byte_ready` is 0 leaves `rx_byte` unchanged.
- R7: If a byte completes while `byte_ready` is 1 and no read happens in that cycle, `overrun` becomes 1, and `rx_byte` and `frame_err` keep the earlier byte's values.
- R8: A stop sample of 0 still delivers the byte and sets `frame_err` to 1. `frame_err` describes the held byte, so the next good byte that is delivered clears it.
- R9: After a low stop sample, the receiver takes no new start until it has seen a high sample. A line held low after the bad stop bit creates no byte and no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial line, idle high |
| os_tick | input | 1 | One-cycle strobe at eight times the bit rate |
| host_rd | input | 1 | One-cycle read strobe for the held byte |
| rx_byte | output | DATA_W | Held received byte |
| byte_ready | output | 1 | Held byte is unread |
| overrun | output | 1 | A byte was lost because the held byte was unread |
| frame_err | output | 1 | The held byte had a low stop sample |

## Verification
The bench builds the receiver with its default parameters: eight data bits, eight samples per bit and a four-sample start check. It raises the tick every fourth clock, so one frame takes about 320 cycles and the tick phase relative to line edges varies from frame to frame. This makes several things reachable in a short run: start-check aborts after 2 and 3 low samples, frames with no tick at all, back-to-back bytes that cause overrun, and a long break after a bad stop bit. Data patterns whose bit reversal differs from the original expose any error in bit order.

// File: rtl/os_uart_rx_pkg.sv
package os_uart_rx_pkg;

    // Receive controller states
    typedef enum logic [2:0] {
        RX_IDLE      = 3'd0,
        RX_START_CHK = 3'd1,
        RX_DATA      = 3'd2,
        RX_STOP      = 3'd3,
        RX_WAIT_HIGH = 3'd4
    } rx_state_e;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    logic [STAGES-1:0] flops;

    // Flops reset to 1 because the line idles high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flops <= '1;
        end else begin
            flops <= {flops[STAGES-2:0], line_i};
        end
    end

    assign line_o = flops[STAGES-1];

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import os_uart_rx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OSR     = 8,
    parameter int CONFIRM = 4   // must be between 2 and OSR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              line_s,
    output rx_state_e         state_o,
    output logic              commit_o,
    output logic [DATA_W-1:0] byte_o,
    output logic              stop_bad_o
);

    localparam int SMP_W = (OSR > 1) ? $clog2(OSR) : 1;
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [SMP_W-1:0] SMP_LAST  = SMP_W'(OSR - 1);
    localparam logic [SMP_W-1:0] CONF_LAST = SMP_W'(CONFIRM - 1);
    localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(DATA_W - 1);

    rx_state_e         state, nxt;
    logic [SMP_W-1:0]  smp_cnt;
    logic [BIT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic              at_mid;

    assign at_mid = os_tick && (smp_cnt == SMP_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE: begin
                if (os_tick && !line_s) nxt = RX_START_CHK;
            end
            RX_START_CHK: begin
                if (os_tick) begin
                    if (line_s)                     nxt = RX_IDLE;
                    else if (smp_cnt == CONF_LAST)  nxt = RX_DATA;
                end
            end
            RX_DATA: begin
                if (at_mid && (bit_cnt == BIT_LAST)) nxt = RX_STOP;
            end
            RX_STOP: begin
                if (at_mid) nxt = line_s ? RX_IDLE : RX_WAIT_HIGH;
            end
            RX_WAIT_HIGH: begin
                if (os_tick && line_s) nxt = RX_IDLE;
            end
            default: nxt = RX_IDLE;
        endcase
    end

    // Sample counter, bit counter and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_cnt <= '0;
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (os_tick) begin
            unique case (state)
                RX_IDLE: begin
                    smp_cnt <= SMP_W'(1);   // first low sample counts
                    bit_cnt <= '0;
                end
                RX_START_CHK: begin
                    if (smp_cnt == CONF_LAST) smp_cnt <= '0;
                    else                      smp_cnt <= smp_cnt + 1'b1;
                end
                RX_DATA: begin
                    if (smp_cnt == SMP_LAST) begin
                        smp_cnt <= '0;
                        shreg   <= {line_s, shreg[DATA_W-1:1]};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else begin
                        smp_cnt <= smp_cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (smp_cnt == SMP_LAST) smp_cnt <= '0;
                    else                     smp_cnt <= smp_cnt + 1'b1;
                end
                RX_WAIT_HIGH: begin
                    smp_cnt <= '0;
                end
                default: smp_cnt <= '0;
            endcase
        end
    end

    assign state_o    = state;
    assign commit_o   = (state == RX_STOP) && at_mid;
    assign byte_o     = shreg;
    assign stop_bad_o = !line_s;

endmodule

// File: rtl/rx_hold_reg.sv
module rx_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [DATA_W-1:0] new_byte,
    input  logic              new_bad,
    input  logic              host_rd,
    output logic [DATA_W-1:0] held_byte,
    output logic              full,
    output logic              lost,
    output logic              held_bad
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_byte <= '0;
            full      <= 1'b0;
            lost      <= 1'b0;
            held_bad  <= 1'b0;
        end else if (commit) begin
            if (full && !host_rd) begin
                lost <= 1'b1;           // keep the unread byte
            end else begin
                held_byte <= new_byte;
                held_bad  <= new_bad;
                full      <= 1'b1;
                lost      <= 1'b0;
            end
        end else if (host_rd) begin
            full <= 1'b0;
            lost <= 1'b0;
        end
    end

endmodule

// File: rtl/os_uart_rx.sv
module os_uart_rx
    import os_uart_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OSR         = 8,
    parameter int CONFIRM     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              os_tick,
    input  logic              host_rd,
    output logic [DATA_W-1:0] rx_byte,
    output logic              byte_ready,
    output logic              overrun,
    output logic              frame_err
);

    logic              line_s;
    rx_state_e         fsm_state;
    logic              commit;
    logic [DATA_W-1:0] asm_byte;
    logic              stop_bad;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (rx_line),
        .line_o (line_s)
    );

    rx_frame_fsm #(
        .DATA_W  (DATA_W),
        .OSR     (OSR),
        .CONFIRM (CONFIRM)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .os_tick    (os_tick),
        .line_s     (line_s),
        .state_o    (fsm_state),
        .commit_o   (commit),
        .byte_o     (asm_byte),
        .stop_bad_o (stop_bad)
    );

    rx_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .new_byte  (asm_byte),
        .new_bad   (stop_bad),
        .host_rd   (host_rd),
        .held_byte (rx_byte),
        .full      (byte_ready),
        .lost      (overrun),
        .held_bad  (frame_err)
    );

endmodule

module os_uart_rx_chk
    import os_uart_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              os_tick,
    input logic              host_rd,
    input logic              line_s,
    input rx_state_e         fsm_state,
    input logic [DATA_W-1:0] rx_byte,
    input logic              byte_ready,
    input logic              overrun
);

    AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        !os_tick |=> $stable(fsm_state)); // R2

    AST_START_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == RX_START_CHK) && os_tick && line_s |=> (fsm_state == RX_IDLE)); // R3

    AST_LOAD_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_ready) |-> ($past(fsm_state) == RX_STOP)); // R5

    AST_READ_CLEARS_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> !overrun); // R6

    AST_LOST_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> byte_ready); // R7

    AST_HELD_BYTE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready && !host_rd |=> $stable(rx_byte)); // R7

    AST_WAIT_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == RX_WAIT_HIGH) && !line_s |=> (fsm_state == RX_WAIT_HIGH)); // R9

endmodule

bind os_uart_rx os_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .os_tick    (os_tick),
    .host_rd    (host_rd),
    .line_s     (line_s),
    .fsm_state  (fsm_state),
    .rx_byte    (rx_byte),
    .byte_ready (byte_ready),
    .overrun    (overrun)
);

// File: tb/tb_os_uart_rx.sv
module tb_os_uart_rx;

    localparam int BIT_CLKS = 32;   // 8 ticks of 4 clocks each

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       os_tick = 1'b0;
    logic       tick_en = 1'b0;
    logic       host_rd = 1'b0;
    logic [1:0] tdiv = 2'd0;
    logic [7:0] rx_byte;
    logic       byte_ready, overrun, frame_err;

    int compared = 0;
    int mismatched = 0;

    always #10 clk = ~clk;  // 50 MHz

    always_ff @(posedge clk) begin
        tdiv    <= tdiv + 2'd1;
        os_tick <= tick_en && (tdiv == 2'd3);
    end

    os_uart_rx dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_line    (rx_line),
        .os_tick    (os_tick),
        .host_rd    (host_rd),
        .rx_byte    (rx_byte),
        .byte_ready (byte_ready),
        .overrun    (overrun),
        .frame_err  (frame_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop_val);
        rx_line = 1'b0;
        wait_clks(BIT_CLKS);
        for (int i = 0; i < 8; i++) begin
            rx_line = b[i];
            wait_clks(BIT_CLKS);
        end
        rx_line = stop_val;
        wait_clks(BIT_CLKS);
        rx_line = 1'b1;
    endtask

    task automatic pulse_read();
        @(negedge clk);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 byte_ready", byte_ready, 0);
        check("R1 overrun", overrun, 0);
        check("R1 frame_err", frame_err, 0);
        check("R1 rx_byte", rx_byte, 8'h00);
    endtask

    task automatic t_bytes();
        logic [7:0] pats [3] = '{8'h01, 8'hE4, 8'h37};
        for (int k = 0; k < 3; k++) begin
            send_frame(pats[k], 1'b1);
            wait_clks(BIT_CLKS + k);   // shifts tick phase per frame
            check("R4 LSB-first byte", rx_byte, pats[k]);
            check("R5 byte_ready set", byte_ready, 1);
            check("R8 frame_err clear on good stop", frame_err, 0);
            pulse_read();
            check("R6 read clears ready", byte_ready, 0);
        end
        pulse_read();
        check("R6 empty read keeps byte", rx_byte, 8'h37);
        check("R6 empty read keeps ready low", byte_ready, 0);
    endtask

    task automatic t_no_tick();
        tick_en = 1'b0;
        wait_clks(8);
        rx_line = 1'b0;
        wait_clks(100);
        rx_line = 1'b1;
        wait_clks(10);
        tick_en = 1'b1;
        wait_clks(2 * BIT_CLKS);
        check("R2 no byte without ticks", byte_ready, 0);
        send_frame(8'h6D, 1'b1);
        wait_clks(BIT_CLKS);
        check("R2 idle after tickless low", rx_byte, 8'h6D);
        pulse_read();
    endtask

    task automatic t_glitch();
        for (int w = 2; w <= 3; w++) begin
            rx_line = 1'b0;
            wait_clks(4 * w);
            rx_line = 1'b1;
            wait_clks(12 * BIT_CLKS);
            check("R3 short low gives no byte", byte_ready, 0);
        end
        send_frame(8'hB1, 1'b1);
        wait_clks(BIT_CLKS);
        check("R3 start after aborted checks", rx_byte, 8'hB1);
        pulse_read();
    endtask

    task automatic t_overrun();
        send_frame(8'hE4, 1'b1);
        wait_clks(BIT_CLKS);
        send_frame(8'h37, 1'b1);
        wait_clks(BIT_CLKS);
        check("R7 overrun set", overrun, 1);
        check("R7 old byte kept", rx_byte, 8'hE4);
        check("R7 ready still set", byte_ready, 1);
        pulse_read();
        check("R6 read clears overrun", overrun, 0);
        check("R6 read clears ready after overrun", byte_ready, 0);
    endtask

    task automatic t_frame_err();
        send_frame(8'h96, 1'b0);
        rx_line = 1'b0;              // break continues past bad stop bit
        wait_clks(3 * BIT_CLKS);
        rx_line = 1'b1;
        wait_clks(BIT_CLKS);
        check("R8 frame_err set", frame_err, 1);
        check("R8 byte delivered", rx_byte, 8'h96);
        check("R8 ready set", byte_ready, 1);
        check("R9 no overrun from break", overrun, 0);
        pulse_read();
        wait_clks(BIT_CLKS);
        check("R9 no byte from break", byte_ready, 0);
        send_frame(8'h2B, 1'b1);
        wait_clks(BIT_CLKS);
        check("R8 next good byte clears frame_err", frame_err, 0);
        check("R9 receive after break", rx_byte, 8'h2B);
        pulse_read();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        wait_clks(5);
        t_reset();
        rst_n = 1'b1;
        wait_clks(3);
        tick_en = 1'b1;
        wait_clks(BIT_CLKS);
        t_bytes();
        t_no_tick();
        t_glitch();
        t_overrun();
        t_frame_err();
        wait_clks(10);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule